// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers interrupt requests for a processor into two local groups of eight sources each and one mapped group of eight sources. Each local group has a read-only status word and a mask word. The block asserts one CPU interrupt line per local group while any unmasked status bit of that group is set.

The mapped group has one status word and two independent mask words. The status word ANDed with the first mask gives mapped sources 16 to 23, which fold into local group 0 status bit 7. The same status ANDed with the second mask gives sources 24 to 31, which fold into local group 1 status bit 3. Two timer interrupt latches are set by single-cycle pulses and feed local group 1 status bits 0 and 1. Software clears them through a write-only register.

Software reaches the registers through a simple synchronous port with an address, write data and a write enable. Read data is registered. All request lines are asynchronous and pass through a two-flop synchronizer.

Top module: `casc_irq_ctrl`

## Requirements
- R1: Reset clears all four mask registers and both timer latches, so `cpu_irq` is 0 and every mask reads 0.
- R2: Local request line i (0..15) appears as local status bit i mod 8 of group i/8 two clock edges after it changes. Mapped request line j appears as mapped status bit j after the same two edges.
- R3: `cpu_irq[0]` is high exactly while (local 0 status AND local 0 mask) is non-zero. `cpu_irq[1]` follows the same rule with the group 1 registers. Both outputs are combinational from the registers.
- R4: Local 0 status bit 7 is the OR of request line 7 with the reduction OR of (mapped status AND mapped mask 0).
- R5: Local 1 status bit 3 is the OR of request line 11 with the reduction OR of (mapped status AND mapped mask 1).
- R6: The register offsets are fixed. Local 0 status is at 0x00, local 0 mask at 0x04, local 1 status at 0x08, local 1 mask at 0x0C and mapped status at 0x10. Mapped mask N is at 0x14 + 4*N. The timer clear register is at 0x1C. Data is in bits 7:0 and reads return zero above bit 7.
- R7: A timer pulse on input bit k sets timer latch k, which is ORed into local 1 status bit k. A write to 0x1C clears latch k when write-data bit k is 1, so writing 0x03 clears both latches.
- R8: When a timer pulse and a clear of the same latch arrive in the same cycle, the latch ends up set.
- R9: Writes to the three status offsets change no register.
- R10: Reads of 0x1C, or of any offset not listed in R6, return 0.
- R11: `reg_rdata` presents, one edge after the address is sampled, the register value held at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcl_req | input | 16 | Raw local request levels; bits 7:0 go to group 0, bits 15:8 to group 1 |
| map_req | input | 8 | Raw mapped request levels |
| tmr_pulse | input | 2 | Single-cycle timer event pulses, synchronous to clk |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable |
| reg_rdata | output | 32 | Registered read data |
| cpu_irq | output | 2 | Interrupt lines to the CPU, one for each local group |

## Verification
The hardest case to reach is a cascade bit raised by the mapped group while a raw request at the same local bit position, a timer latch and a clear all act together. Each of these inputs reaches the status word at a different depth: the requests cross two synchronizer flops, while the latches and the masks change in one edge. The directed phase builds each of these collisions by hand. This includes a timer pulse issued in the same cycle as a clear write. A long random phase then mixes request levels, pulses and accesses to every offset plus some unmapped ones. On every clock a behavioural model tracks the delays and predicts `cpu_irq` and the read data.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
  localparam int GRP_W   = 8;
  localparam int N_MASK  = 4;
  localparam int N_TMR   = 2;
  // register byte offsets
  localparam logic [7:0] OFF_L0_STAT = 8'h00;
  localparam logic [7:0] OFF_L1_STAT = 8'h08;
  localparam logic [7:0] OFF_MP_STAT = 8'h10;
  localparam logic [7:0] OFF_TCLR    = 8'h1C;
  // mask index: 0 local0, 1 local1, 2 mapped0, 3 mapped1
  localparam logic [7:0] OFF_MP_MASK0 = 8'h14;

  function automatic logic [7:0] mask_off(input int idx);
    case (idx)
      0:       mask_off = 8'h04;
      1:       mask_off = 8'h0C;
      default: mask_off = OFF_MP_MASK0 + 8'((idx - 2) * 4);
    endcase
  endfunction
endpackage

// File: rtl/casc_irq_sync.sv
module casc_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/casc_irq_tmr.sv
module casc_irq_tmr #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic nxt;
    always_comb begin
      nxt = q[k];
      if (clr[k]) nxt = 1'b0;
      if (set[k]) nxt = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[k] <= 1'b0;
      else        q[k] <= nxt;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[k] |=> q[k]);
    // R7
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && !set[k]) |=> !q[k]);
  end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import casc_irq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       lcl_req,
  input  logic [7:0]        map_req,
  input  logic [1:0]        tmr_pulse,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        cpu_irq
);
  localparam int CASC0_BIT = 7;
  localparam int CASC1_BIT = 3;

  logic [2*GRP_W-1:0] lcl_sync;
  logic [GRP_W-1:0]   map_sync;
  logic [N_TMR-1:0]   tmr_q, tmr_clr;
  logic [GRP_W-1:0]   mask_q [N_MASK];
  logic [GRP_W-1:0]   l0_stat, l1_stat;
  logic               casc0, casc1;
  logic [DATA_W-1:0]  rdata_d;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:GRP_W];

  casc_irq_sync #(.W(2*GRP_W)) u_lcl_sync (
    .clk(clk), .rst_n(rst_n), .d(lcl_req), .q(lcl_sync));
  casc_irq_sync #(.W(GRP_W)) u_map_sync (
    .clk(clk), .rst_n(rst_n), .d(map_req), .q(map_sync));

  assign tmr_clr = (reg_we && reg_addr == ADDR_W'(OFF_TCLR)) ? reg_wdata[N_TMR-1:0] : '0;

  casc_irq_tmr #(.N(N_TMR)) u_tmr (
    .clk(clk), .rst_n(rst_n), .set(tmr_pulse), .clr(tmr_clr), .q(tmr_q));

  // mask registers, one per decoded offset
  for (genvar g = 0; g < N_MASK; g++) begin : g_mask
    logic             hit;
    logic [GRP_W-1:0] nxt;
    assign hit = reg_we && (reg_addr == ADDR_W'(mask_off(g)));
    always_comb begin
      nxt = mask_q[g];
      if (hit) nxt = reg_wdata[GRP_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[g] <= '0;
      else        mask_q[g] <= nxt;
    end
  end

  // cascade of the mapped group into the local groups
  assign casc0 = |(map_sync & mask_q[2]);
  assign casc1 = |(map_sync & mask_q[3]);

  always_comb begin
    l0_stat = lcl_sync[GRP_W-1:0];
    l0_stat[CASC0_BIT] = l0_stat[CASC0_BIT] | casc0;
    l1_stat = lcl_sync[2*GRP_W-1:GRP_W];
    l1_stat[CASC1_BIT] = l1_stat[CASC1_BIT] | casc1;
    l1_stat[N_TMR-1:0] = l1_stat[N_TMR-1:0] | tmr_q;
  end

  assign cpu_irq = {|(l1_stat & mask_q[1]), |(l0_stat & mask_q[0])};

  // registered read port
  always_comb begin
    rdata_d = '0;
    case (reg_addr)
      ADDR_W'(OFF_L0_STAT):  rdata_d[GRP_W-1:0] = l0_stat;
      ADDR_W'(OFF_L1_STAT):  rdata_d[GRP_W-1:0] = l1_stat;
      ADDR_W'(OFF_MP_STAT):  rdata_d[GRP_W-1:0] = map_sync;
      ADDR_W'(mask_off(0)):  rdata_d[GRP_W-1:0] = mask_q[0];
      ADDR_W'(mask_off(1)):  rdata_d[GRP_W-1:0] = mask_q[1];
      ADDR_W'(mask_off(2)):  rdata_d[GRP_W-1:0] = mask_q[2];
      ADDR_W'(mask_off(3)):  rdata_d[GRP_W-1:0] = mask_q[3];
      default:               rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rdata_d;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (cpu_irq == 2'b00);
    end
  end
  // R4
  casc0_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(map_sync & mask_q[2]) && mask_q[0][CASC0_BIT]) |-> cpu_irq[0]);
  // R5
  casc1_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(map_sync & mask_q[3]) && mask_q[1][CASC1_BIT]) |-> cpu_irq[1]);
  // R9
  stat_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == ADDR_W'(OFF_L0_STAT) || reg_addr == ADDR_W'(OFF_L1_STAT) ||
                reg_addr == ADDR_W'(OFF_MP_STAT)))
    |=> ($stable(mask_q[0]) && $stable(mask_q[1]) && $stable(mask_q[2]) && $stable(mask_q[3])));
  // R10
  tclr_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFF_TCLR)) |=> (reg_rdata == '0));
endmodule

// File: tb/casc_irq_ctrl_tb.sv
module casc_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lcl_req = '0;
  logic [7:0]  map_req = '0;
  logic [1:0]  tmr_pulse = '0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [1:0]  cpu_irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  casc_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .lcl_req(lcl_req), .map_req(map_req),
    .tmr_pulse(tmr_pulse), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq));

  // behavioural reference state
  bit [15:0] s1l, s2l;
  bit [7:0]  s1m, s2m;
  bit [7:0]  mm [4];
  bit [1:0]  tl;
  bit [31:0] m_rd;

  function automatic bit [7:0] st0();
    return s2l[7:0] | ((|(s2m & mm[2])) ? 8'h80 : 8'h00);
  endfunction
  function automatic bit [7:0] st1();
    return s2l[15:8] | ((|(s2m & mm[3])) ? 8'h08 : 8'h00) | {6'b0, tl};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1l = '0; s2l = '0; s1m = '0; s2m = '0; tl = '0; m_rd = '0;
      for (int i = 0; i < 4; i++) mm[i] = '0;
    end else begin
      bit [1:0] clr;
      case (reg_addr)
        6'h00: m_rd = {24'b0, st0()};
        6'h04: m_rd = {24'b0, mm[0]};
        6'h08: m_rd = {24'b0, st1()};
        6'h0C: m_rd = {24'b0, mm[1]};
        6'h10: m_rd = {24'b0, s2m};
        6'h14: m_rd = {24'b0, mm[2]};
        6'h18: m_rd = {24'b0, mm[3]};
        default: m_rd = '0;
      endcase
      clr = '0;
      if (reg_we) begin
        case (reg_addr)
          6'h04: mm[0] = reg_wdata[7:0];
          6'h0C: mm[1] = reg_wdata[7:0];
          6'h14: mm[2] = reg_wdata[7:0];
          6'h18: mm[3] = reg_wdata[7:0];
          6'h1C: clr = reg_wdata[1:0];
          default: ;
        endcase
      end
      tl  = tmr_pulse | (tl & ~clr);
      s2l = s1l; s1l = lcl_req;
      s2m = s1m; s1m = map_req;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit [1:0] exp_irq;
      exp_irq = {|(st1() & mm[1]), |(st0() & mm[0])};
      n_cmp++;
      if (cpu_irq !== exp_irq) begin
        n_bad++;
        $display("FAIL R3 cpu_irq act=%b exp=%b t=%0t", cpu_irq, exp_irq, $time);
      end
      n_cmp++;
      if (reg_rdata !== m_rd) begin
        n_bad++;
        $display("FAIL R11 reg_rdata act=%h exp=%h t=%0t", reg_rdata, m_rd, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 6'h3C;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
    reg_addr = 6'h3C;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    reg_addr = 6'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 cpu_irq", {30'b0, cpu_irq}, 0);
    rd(6'h04, v); chk("R1 l0 mask", v, 0);
    rd(6'h18, v); chk("R1 map mask1", v, 0);
    // R2 / R3 local path
    wr(6'h04, 32'hFF);
    lcl_req = 16'h0005;
    idle(3);
    rd(6'h00, v); chk("R2 l0 status", v, 32'h05);
    chk("R3 irq0 high", {31'b0, cpu_irq[0]}, 1);
    // R9 status write ignored
    wr(6'h00, 32'hAA);
    wr(6'h10, 32'h55);
    rd(6'h04, v); chk("R9 l0 mask kept", v, 32'hFF);
    rd(6'h00, v); chk("R9 l0 status kept", v, 32'h05);
    // R4 cascade into group 0 bit 7
    lcl_req = 16'h0000; map_req = 8'h10;
    wr(6'h14, 32'h10);
    idle(3);
    rd(6'h00, v); chk("R4 l0 cascade bit", v, 32'h80);
    rd(6'h10, v); chk("R2 map status", v, 32'h10);
    wr(6'h04, 32'h7F);
    chk("R3 irq0 masked", {31'b0, cpu_irq[0]}, 0);
    // R5 / R6 cascade into group 1 bit 3 via second mask
    wr(6'h0C, 32'h08);
    wr(6'h18, 32'h10);
    rd(6'h08, v); chk("R5 l1 cascade bit", v, 32'h08);
    chk("R5 irq1", {31'b0, cpu_irq[1]}, 1);
    rd(6'h18, v); chk("R6 map mask1 offset", v, 32'h10);
    rd(6'h14, v); chk("R6 map mask0 offset", v, 32'h10);
    // R7 timer latch set and clear
    @(negedge clk); tmr_pulse = 2'b01;
    @(negedge clk); tmr_pulse = 2'b00;
    rd(6'h08, v); chk("R7 timer latch set", v, 32'h09);
    wr(6'h1C, 32'h03);
    rd(6'h08, v); chk("R7 timer cleared", v, 32'h08);
    // R8 set wins over clear in the same cycle
    @(negedge clk);
    tmr_pulse = 2'b10; reg_addr = 6'h1C; reg_wdata = 32'h3; reg_we = 1'b1;
    @(negedge clk);
    tmr_pulse = 2'b00; reg_we = 1'b0;
    rd(6'h08, v); chk("R8 set wins", v, 32'h0A);
    // R10 unmapped and write-only reads
    rd(6'h1C, v); chk("R10 tclr reads 0", v, 0);
    rd(6'h24, v); chk("R10 unmapped 0x24", v, 0);
    rd(6'h05, v); chk("R10 unaligned", v, 0);
    // random phase, checked every clock by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      lcl_req   = 16'($urandom);
      map_req   = 8'($urandom);
      tmr_pulse = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      reg_addr  = (($urandom % 6) == 0) ? 6'($urandom) : 6'(($urandom % 9) * 4);
      reg_wdata = $urandom;
      reg_we    = (($urandom % 3) == 0);
    end
    @(negedge clk); reg_we = 1'b0;
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule